// File: doc/BRIEF.md
# FEAC Codeword Transmit Sequencer

This block produces the far-end alarm and control bit stream carried in a DS3 C-bit overhead channel. The host programs two 6-bit codewords, A and B, and drives a 2-bit action select. The framer asserts a channel enable strobe at each position that the channel owns. On each strobe the block shifts out the next bit of a framed codeword, or a one when there is nothing to send.

There are three actions. The first sends A ten times. The second sends A ten times and then B ten times. The third repeats A until the host releases it, with a minimum of ten copies. An action starts only when the select moves from zero to a nonzero value. Actions one and two always finish once started. A registered status output tells the host when the line carries only idle ones.

Top module: `feac_tx_seq`

## Requirements
- R1: After reset, and for as long as the select stays 2'b00, `tx_bit` is 1 on every strobe and `tx_idle` is 1.
- R2: Each codeword takes 16 strobes. The bits go out in this order: a 0, then the six codeword bits with bit 0 first, then a 0, then eight 1s.
- R3: Select 2'b01 sends codeword A exactly ten times. After that the output is all ones.
- R4: Select 2'b10 sends codeword A ten times, then codeword B ten times. After that the output is all ones.
- R5: Select 2'b11 repeats codeword A. The repetition ends at the end of the codeword in progress once the select reads 2'b00 and at least ten copies have gone out. A release before the tenth copy therefore yields exactly ten copies.
- R6: An action starts only when the select changes from 2'b00 to a nonzero value. The following have no effect: holding a nonzero select after an action ends, changing from one nonzero value to another, and any change made while an action is running.
- R7: Actions 2'b01 and 2'b10 send their full sequence even if the select returns to 2'b00 partway through.
- R8: `tx_idle` is 1 while the bit being sent is an idle one. It is 0 while the bit belongs to a codeword.
- R9: `tx_bit` and `tx_idle` change only after a clock edge on which `bit_en` is high. They hold their values between strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Channel enable strobe: one output bit per high cycle |
| act_sel | input | 2 | Action select (00 idle, 01 A×10, 10 A×10 then B×10, 11 A until released) |
| code_a | input | 6 | Codeword A |
| code_b | input | 6 | Codeword B |
| tx_bit | output | 1 | Serial channel bit |
| tx_idle | output | 1 | High while idle ones are being sent |

## Verification
The hardest case to reach is a release of the continuous action. The release must land partway through a codeword, both before and after the ten-copy minimum, so that both the boundary rule and the minimum count are exercised. The stimulus counts strobes to place the write to 2'b00 at chosen bit positions: after the second copy, and in the middle of the twenty-sixth. It then checks that the current word finishes and that the next strobe carries an idle one. A second hard case is an edge that the block must ignore. To reach it, the stimulus leaves the select nonzero after an action completes, and then moves the select directly from one nonzero value to another.

// File: rtl/feac_tx_seq.sv
module feac_tx_seq #(
  parameter int REPS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [1:0] act_sel,
  input  logic [5:0] code_a,
  input  logic [5:0] code_b,
  output logic       tx_bit,
  output logic       tx_idle
);

  localparam int RW = $clog2(REPS + 2);

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_A = 2'd1, ST_B = 2'd2} st_t;

  st_t           st;
  logic [1:0]    sel_q;
  logic [1:0]    mode;
  logic [3:0]    bit_idx;
  logic [RW-1:0] rep;
  logic [5:0]    cur;
  logic          frame_bit;

  wire           busy    = (st != ST_IDLE);
  wire           start   = (sel_q == 2'b00) && (act_sel != 2'b00) && !busy;
  wire [5:0]     src     = (st == ST_B) ? code_b : code_a;
  wire           last    = (bit_idx == 4'd15);
  wire [RW-1:0]  rep_nx  = rep + 1'b1;
  wire           min_met = (rep_nx >= RW'(REPS));
  wire           done10  = (rep_nx == RW'(REPS));

  always_comb begin
    if (bit_idx == 4'd0 || bit_idx == 4'd7) frame_bit = 1'b0;
    else if (bit_idx < 4'd7)                frame_bit = cur[bit_idx[2:0] - 3'd1];
    else                                    frame_bit = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      sel_q   <= 2'b00;
      mode    <= 2'b00;
      bit_idx <= 4'd0;
      rep     <= '0;
      cur     <= 6'd0;
      tx_bit  <= 1'b1;
      tx_idle <= 1'b1;
    end else begin
      sel_q <= act_sel;
      if (start) begin
        st      <= ST_A;
        mode    <= act_sel;
        bit_idx <= 4'd0;
        rep     <= '0;
      end
      if (bit_en) begin
        if (!busy) begin
          tx_bit  <= 1'b1;
          tx_idle <= 1'b1;
        end else begin
          tx_bit  <= frame_bit;
          tx_idle <= 1'b0;
          bit_idx <= bit_idx + 4'd1;
          if (bit_idx == 4'd0) cur <= src;
          if (last) begin
            case (st)
              ST_A: begin
                if (mode == 2'b11) begin
                  if (min_met && act_sel == 2'b00) st <= ST_IDLE;
                  rep <= min_met ? RW'(REPS) : rep_nx;
                end else if (done10) begin
                  st  <= (mode == 2'b10) ? ST_B : ST_IDLE;
                  rep <= (mode == 2'b10) ? '0 : rep;
                end else begin
                  rep <= rep_nx;
                end
              end
              ST_B: begin
                if (done10) st <= ST_IDLE;
                else        rep <= rep_nx;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
      end
    end
  end

endmodule

module feac_tx_seq_chk #(
  parameter int REPS = 10,
  parameter int RW   = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_en,
  input logic          tx_bit,
  input logic          tx_idle,
  input logic          busy,
  input logic [1:0]    sel_q,
  input logic [3:0]    bit_idx,
  input logic [RW-1:0] rep,
  input logic [1:0]    mode
);

  // R9
  hold_between_strobes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit) && $stable(tx_idle));

  // R8
  idle_means_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_idle |-> tx_bit);

  // R6
  start_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sel_q) == 2'b00);

  // R5
  end_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(bit_en) && $past(bit_idx) == 4'd15);

  // R7
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(mode) == 2'b11) || ($past(rep) == RW'(REPS - 1)));

endmodule

bind feac_tx_seq feac_tx_seq_chk #(.REPS(REPS), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .tx_bit(tx_bit), .tx_idle(tx_idle),
  .busy(busy), .sel_q(sel_q), .bit_idx(bit_idx), .rep(rep), .mode(mode)
);

// File: tb/feac_tx_seq_tb.sv
`timescale 1ns/1ps
module feac_tx_seq_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic [1:0] act_sel = 2'b00;
  logic [5:0] code_a = 6'b001011;
  logic [5:0] code_b = 6'b110100;
  logic tx_bit, tx_idle;

  int checks = 0;
  int errors = 0;
  int gap = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  feac_tx_seq u_dut (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .act_sel(act_sel),
    .code_a(code_a), .code_b(code_b), .tx_bit(tx_bit), .tx_idle(tx_idle)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_bit(input logic [5:0] c, input int i);
    if (i == 0 || i == 7) return 1'b0;
    if (i < 7) return c[i-1];
    return 1'b1;
  endfunction

  task automatic set_sel(input logic [1:0] v);
    @(negedge clk) act_sel = v;
  endtask

  task automatic strobe_get(output logic b, output logic id);
    @(negedge clk) bit_en = 1'b1;
    @(negedge clk) bit_en = 1'b0;
    b = tx_bit;
    id = tx_idle;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      chk("R9 hold bit", tx_bit, b);
      chk("R9 hold idle", tx_idle, id);
    end
  endtask

  task automatic send_word(input logic [5:0] c, input string req);
    logic b, id;
    for (int i = 0; i < 16; i++) begin
      strobe_get(b, id);
      chk(req, b, exp_bit(c, i));
      chk("R8 busy status", id, 1'b0);
    end
  endtask

  task automatic expect_ones(input int n, input string req);
    logic b, id;
    for (int i = 0; i < n; i++) begin
      strobe_get(b, id);
      chk(req, b, 1'b1);
      chk("R8 idle status", id, 1'b1);
    end
  endtask

  task automatic t_reset;
    chk("R1 reset bit", tx_bit, 1'b1);
    chk("R1 reset idle", tx_idle, 1'b1);
    expect_ones(32, "R1 idle select");
  endtask

  task automatic t_act01;
    set_sel(2'b01);
    send_word(code_a, "R2 frame");
    for (int w = 1; w < 3; w++) send_word(code_a, "R3 A word");
    set_sel(2'b00);
    for (int w = 3; w < 10; w++) send_word(code_a, "R7 completes");
    expect_ones(24, "R3 ones after");
  endtask

  task automatic t_retrig;
    set_sel(2'b01);
    for (int w = 0; w < 10; w++) send_word(code_a, "R3 A word");
    expect_ones(32, "R6 held select");
    set_sel(2'b10);
    expect_ones(32, "R6 nonzero change");
    set_sel(2'b00);
  endtask

  task automatic t_act10;
    set_sel(2'b10);
    for (int w = 0; w < 2; w++) send_word(code_a, "R4 A word");
    set_sel(2'b00);
    for (int w = 2; w < 10; w++) send_word(code_a, "R7 A word");
    for (int w = 0; w < 10; w++) send_word(code_b, "R4 B word");
    expect_ones(24, "R4 ones after");
  endtask

  task automatic t_busy_edge;
    set_sel(2'b01);
    send_word(code_a, "R3 A word");
    set_sel(2'b00);
    set_sel(2'b10);
    for (int w = 1; w < 10; w++) send_word(code_a, "R6 edge while busy");
    expect_ones(24, "R6 no second action");
    set_sel(2'b00);
  endtask

  task automatic t_act11_long;
    logic b, id;
    set_sel(2'b11);
    for (int w = 0; w < 25; w++) send_word(code_a, "R5 repeat");
    for (int i = 0; i < 5; i++) begin
      strobe_get(b, id);
      chk("R5 mid word", b, exp_bit(code_a, i));
    end
    set_sel(2'b00);
    for (int i = 5; i < 16; i++) begin
      strobe_get(b, id);
      chk("R5 word finishes", b, exp_bit(code_a, i));
      chk("R8 busy status", id, 1'b0);
    end
    expect_ones(24, "R5 released");
  endtask

  task automatic t_act11_early;
    set_sel(2'b11);
    for (int w = 0; w < 2; w++) send_word(code_a, "R5 repeat");
    set_sel(2'b00);
    for (int w = 2; w < 10; w++) send_word(code_a, "R5 minimum ten");
    expect_ones(24, "R5 after minimum");
  endtask

  task automatic t_hold;
    gap = 3;
    set_sel(2'b01);
    for (int w = 0; w < 10; w++) send_word(code_a, "R9 gapped word");
    expect_ones(8, "R9 gapped ones");
    set_sel(2'b00);
    gap = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_act01;
    t_retrig;
    t_act10;
    t_busy_edge;
    t_act11_long;
    t_act11_early;
    code_a = 6'b100110;
    code_b = 6'b011001;
    t_hold;
    t_act10;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule